// File: doc/BRIEF.md
# Instruction Fetch Group Aligner

This block feeds a downstream instruction buffer with fetch groups of up to four 32-bit instructions. The groups are read from a small internal line store of 8 rows with 4 instructions each. A fetch address register holds the current position. The row field of that address picks a line. The column field picks the first instruction inside the line, and a slot multiplexer packs the instructions from that column to the end of the line into the lowest output slots. A per-slot mask marks which slots carry an instruction.

A group that starts on a line boundary fills all four slots. A group that starts partway through a line is cut short at the line end. The fetch address then moves to the start of the following row, so the rest of the stream arrives on the next transfer.

The output side is a valid/ready stream. A group is transferred on every clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the group and its address are held unchanged. `out_valid` never depends on `out_ready`. A redirect loads a new fetch address on the next edge and takes priority over both advancing and holding. A load port writes single instructions into the line store.

Top module: `fetch_aligner`

## Requirements
- R1: The fetch address is 7 bits wide. Bits [1:0] are a byte offset that must be zero, bits [3:2] are the column (the instruction within the line), and bits [6:4] are the row.
- R2: When the column is 0, the group fills all four slots. Slot i carries the instruction at column i of the addressed row, and `out_mask` is 4'b1111.
- R3: When the column c is nonzero, slot i carries the instruction at column c+i for every c+i ≤ 3. `out_mask` then has its low 4−c bits set, and every slot outside the mask reads as zero.
- R4: After a transfer (valid and ready high together, no redirect), the fetch address becomes column 0 of the next row. The row number wraps from 7 to 0.
- R5: While `out_ready` is low and no redirect is present, the fetch address and the mask stay unchanged.
- R6: When `redirect_valid` is high at a clock edge, the fetch address becomes `redirect_addr` at that edge. This holds whatever `out_ready` is.
- R7: When byte-offset bits [1:0] are nonzero, `align_err` is 1, `out_mask` is 0, all slots are 0 and `out_valid` is 0. The address then stays put until a redirect arrives.
- R8: A synchronous, active-high reset sets the fetch address to 0.
- R9: When `load_en` is high at an edge, `load_data` is written to row `load_row`, column `load_col`. Every later group that covers that position shows the new value. Loads are accepted during reset as well.
- R10: `out_valid` is 1 exactly when `out_mask` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| redirect_valid | input | 1 | Load a new fetch address on this edge |
| redirect_addr | input | 7 | New fetch address |
| out_valid | output | 1 | A fetch group is presented |
| out_ready | input | 1 | The downstream buffer accepts the group (low means stall) |
| out_instr | output | 128 | Slot i is bits [32i+31:32i] |
| out_mask | output | 4 | Per-slot valid mask, packed from slot 0 |
| out_pc | output | 7 | Fetch address of the presented group |
| align_err | output | 1 | The fetch address has a nonzero byte offset |
| load_en | input | 1 | Write one instruction into the line store |
| load_row | input | 3 | Row to write |
| load_col | input | 2 | Column to write |
| load_data | input | 32 | Instruction to write |

## Verification
The group outputs are driven combinationally from the fetch address register and the line store. A redirect, a transfer or a load made at one rising edge is therefore visible for the whole cycle that follows it, and no later. The bench drives inputs at the falling edge and applies the same edge to its own model at the rising edge. It then compares every output at the next falling edge, exactly one edge after the stimulus. A check that follows an edge is tagged with the cause of that edge: redirect, transfer, stall or alignment hold.

// File: rtl/fa_pkg.sv
package fa_pkg;
  // Shape of the group presented in the current cycle
  typedef enum logic [1:0] {
    GRP_FULL = 2'd0,
    GRP_PART = 2'd1,
    GRP_BAD  = 2'd2
  } grp_kind_t;
endpackage

// File: rtl/fa_line_store.sv
module fa_line_store #(
  parameter int INSTR_W = 32,
  parameter int ROWS    = 8,
  parameter int SLOTS   = 4,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(SLOTS)
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ROW_W-1:0]         wr_row,
  input  logic [COL_W-1:0]         wr_col,
  input  logic [INSTR_W-1:0]       wr_data,
  input  logic [ROW_W-1:0]         rd_row,
  output logic [SLOTS*INSTR_W-1:0] rd_line
);
  logic [INSTR_W-1:0] cells [ROWS][SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_row][wr_col] <= wr_data;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_col
    assign rd_line[s*INSTR_W +: INSTR_W] = cells[rd_row][s];
  end
endmodule

// File: rtl/fa_slot_mux.sv
module fa_slot_mux
  import fa_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int SLOTS   = 4,
  parameter int OFF_W   = 2,
  localparam int COL_W  = $clog2(SLOTS)
) (
  input  logic [SLOTS*INSTR_W-1:0] line,
  input  logic [COL_W-1:0]         col,
  input  logic [OFF_W-1:0]         byte_off,
  output logic [SLOTS*INSTR_W-1:0] grp,
  output logic [SLOTS-1:0]         mask,
  output grp_kind_t                kind
);
  logic misalign;
  assign misalign = (byte_off != '0);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [COL_W:0] src;
    assign src = {1'b0, col} + (COL_W+1)'(i);
    always_comb begin
      grp[i*INSTR_W +: INSTR_W] = '0;
      mask[i] = 1'b0;
      if (!misalign && (int'(src) < SLOTS)) begin
        grp[i*INSTR_W +: INSTR_W] = line[int'(src)*INSTR_W +: INSTR_W];
        mask[i] = 1'b1;
      end
    end
  end

  always_comb begin
    if (misalign)          kind = GRP_BAD;
    else if (col == '0)    kind = GRP_FULL;
    else                   kind = GRP_PART;
  end
endmodule

// File: rtl/fa_fetch_ctrl.sv
module fa_fetch_ctrl #(
  parameter int ROW_W = 3,
  parameter int COL_W = 2,
  parameter int OFF_W = 2,
  parameter int ADDR_W = ROW_W + COL_W + OFF_W,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int LOW_W = COL_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_addr,
  input  logic              accept,
  output logic [ADDR_W-1:0] pc
);
  logic [ROW_W-1:0]  row_nxt;
  logic [ADDR_W-1:0] seq_pc;

  assign row_nxt = pc[ADDR_W-1:LOW_W] + ROW_W'(1);
  assign seq_pc  = {row_nxt, {LOW_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst)           pc <= RESET_ADDR;
    else if (redirect) pc <= redirect_addr;
    else if (accept)   pc <= seq_pc;
  end
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
  import fa_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int ROWS    = 8,
  parameter int SLOTS   = 4,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(SLOTS),
  localparam int OFF_W  = $clog2(INSTR_W/8),
  localparam int ADDR_W = ROW_W + COL_W + OFF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     redirect_valid,
  input  logic [ADDR_W-1:0]        redirect_addr,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [SLOTS*INSTR_W-1:0] out_instr,
  output logic [SLOTS-1:0]         out_mask,
  output logic [ADDR_W-1:0]        out_pc,
  output logic                     align_err,
  input  logic                     load_en,
  input  logic [ROW_W-1:0]         load_row,
  input  logic [COL_W-1:0]         load_col,
  input  logic [INSTR_W-1:0]       load_data
);
  logic [ADDR_W-1:0]        pc;
  logic [SLOTS*INSTR_W-1:0] line;
  grp_kind_t                kind;

  fa_fetch_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W),
    .RESET_ADDR('0)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .redirect(redirect_valid), .redirect_addr(redirect_addr),
    .accept(out_valid && out_ready),
    .pc(pc)
  );

  fa_line_store #(.INSTR_W(INSTR_W), .ROWS(ROWS), .SLOTS(SLOTS)) u_store (
    .clk(clk),
    .wr_en(load_en), .wr_row(load_row), .wr_col(load_col), .wr_data(load_data),
    .rd_row(pc[ADDR_W-1 -: ROW_W]),
    .rd_line(line)
  );

  fa_slot_mux #(.INSTR_W(INSTR_W), .SLOTS(SLOTS), .OFF_W(OFF_W)) u_mux (
    .line(line),
    .col(pc[OFF_W +: COL_W]),
    .byte_off(pc[OFF_W-1:0]),
    .grp(out_instr),
    .mask(out_mask),
    .kind(kind)
  );

  assign out_valid = (kind != GRP_BAD);
  assign align_err = (kind == GRP_BAD);
  assign out_pc    = pc;
endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
  parameter int SLOTS  = 4,
  parameter int ADDR_W = 7,
  parameter int ROW_W  = 3,
  parameter int LOW_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [SLOTS-1:0]  out_mask,
  input logic [ADDR_W-1:0] out_pc,
  input logic              align_err
);
  assert_reset_addr_R8: assert property (@(posedge clk)
    rst |=> (out_pc == '0));

  assert_redirect_R6: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> (out_pc == $past(redirect_addr)));

  assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !redirect_valid) |=>
      ((out_pc[ADDR_W-1:LOW_W] == ROW_W'($past(out_pc[ADDR_W-1:LOW_W]) + 1'b1))
       && (out_pc[LOW_W-1:0] == '0)));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !redirect_valid) |=>
      ($stable(out_pc) && $stable(out_mask)));

  assert_bad_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (align_err && !redirect_valid) |=> $stable(out_pc));

  assert_bad_empty_R7: assert property (@(posedge clk) disable iff (rst)
    align_err |-> (!out_valid && out_mask == '0));

  assert_mask_packed_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_mask & (out_mask + 1'b1)) == '0));

  assert_full_group_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_pc[LOW_W-1:0] == '0) |-> (out_mask == '1));

  assert_valid_mask_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid == (out_mask != '0));
endmodule

bind fetch_aligner fa_checker #(
  .SLOTS(SLOTS), .ADDR_W(ADDR_W), .ROW_W(ROW_W), .LOW_W(COL_W + OFF_W)
) u_fa_checker (
  .clk(clk), .rst(rst),
  .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_mask(out_mask), .out_pc(out_pc), .align_err(align_err)
);

// File: tb/test_fetch_aligner.sv
module test_fetch_aligner;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         redirect_valid = 1'b0;
  logic [6:0]   redirect_addr = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_instr;
  logic [3:0]   out_mask;
  logic [6:0]   out_pc;
  logic         align_err;
  logic         load_en = 1'b0;
  logic [2:0]   load_row = '0;
  logic [1:0]   load_col = '0;
  logic [31:0]  load_data = '0;

  fetch_aligner i_fetch_aligner (
    .clk(clk), .rst(rst),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_instr(out_instr), .out_mask(out_mask), .out_pc(out_pc),
    .align_err(align_err),
    .load_en(load_en), .load_row(load_row), .load_col(load_col),
    .load_data(load_data)
  );

  always #4ns clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  logic [31:0] m_mem [8][4];
  logic [6:0]  m_pc;
  string evt_tag = "R8";

  function automatic logic [3:0] exp_mask();
    if (m_pc[1:0] != 2'b00) return 4'b0000;
    return 4'b1111 >> m_pc[3:2];
  endfunction

  function automatic logic [127:0] exp_instr();
    logic [127:0] g = '0;
    int c = int'(m_pc[3:2]);
    if (m_pc[1:0] == 2'b00)
      for (int i = 0; i < 4; i++)
        if (c + i <= 3) g[i*32 +: 32] = m_mem[m_pc[6:4]][c+i];
    return g;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    string ctag;
    if (m_pc[1:0] != 2'b00)      ctag = "R1 R7";
    else if (m_pc[3:2] == 2'b00) ctag = "R1 R2";
    else                         ctag = "R1 R3";
    check(evt_tag, "out_pc", 128'(out_pc), 128'(m_pc));
    check(ctag, "out_mask", 128'(out_mask), 128'(exp_mask()));
    check(ctag, "out_instr", out_instr, exp_instr());
    check(ctag, "align_err", 128'(align_err), 128'(m_pc[1:0] != 2'b00));
    check("R10", "out_valid", 128'(out_valid), 128'(exp_mask() != 4'b0000));
  endtask

  // one cycle: check at falling edge, drive, model the rising edge
  task automatic step(input logic rd, input logic [6:0] ra, input logic rdy,
                      input logic ld, input logic [2:0] lr, input logic [1:0] lc,
                      input logic [31:0] ldat);
    logic vld;
    check_outputs();
    vld = (exp_mask() != 4'b0000);
    redirect_valid = rd; redirect_addr = ra; out_ready = rdy;
    load_en = ld; load_row = lr; load_col = lc; load_data = ldat;
    @(posedge clk);
    if (ld) m_mem[lr][lc] = ldat;
    if (rd) begin
      m_pc = ra; evt_tag = "R6";
    end else if (vld && rdy) begin
      m_pc = {m_pc[6:4] + 3'd1, 4'b0000}; evt_tag = "R4";
    end else if (vld) evt_tag = "R5";
    else evt_tag = "R7";
    if (ld) evt_tag = {evt_tag, " R9"};
    @(negedge clk);
  endtask

  initial begin
    #800us;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // preload during reset (R9)
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        load_en = 1'b1; load_row = 3'(r); load_col = 2'(c);
        load_data = {8'hA0 + 8'(r), 8'(c), 16'h1234 + 16'(r*4 + c)};
        @(posedge clk);
        m_mem[r][c] = load_data;
      end
    @(negedge clk);
    load_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    m_pc = '0; evt_tag = "R8";
    // reset state and full group, then advance R4
    step(0, '0, 1, 0, '0, '0, '0);
    step(0, '0, 0, 0, '0, '0, '0);           // stall R5
    step(0, '0, 0, 0, '0, '0, '0);
    step(1, 7'b111_01_00, 0, 0, '0, '0, '0); // redirect beats stall R6
    step(0, '0, 1, 0, '0, '0, '0);           // partial 0111 R3, wraps R4
    step(1, 7'b010_11_00, 1, 0, '0, '0, '0); // redirect beats advance R6
    step(0, '0, 1, 0, '0, '0, '0);           // single slot R3
    step(1, 7'b001_00_10, 1, 0, '0, '0, '0); // bad byte offset R7
    step(0, '0, 1, 0, '0, '0, '0);
    step(0, '0, 1, 0, '0, '0, '0);
    step(1, 7'b000_00_00, 0, 1, 3'd3, 2'd2, 32'hDEAD_BEEF); // load R9
    step(1, 7'b011_10_00, 0, 0, '0, '0, '0);
    step(0, '0, 1, 0, '0, '0, '0);
    for (int n = 0; n < 3000; n++) begin
      logic rd = ($urandom % 6) == 0;
      logic [6:0] ra = 7'($urandom);
      if (($urandom % 8) != 0) ra[1:0] = 2'b00;
      step(rd, ra, ($urandom % 4) != 0, ($urandom % 10) == 0,
           3'($urandom), 2'($urandom), $urandom);
    end
    check_outputs();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule